// File: doc/BRIEF.md
# Frame Pulse Alignment Checker

This block watches several parallel SONET/SDH transmit lanes. Each lane has a data word and a frame-pulse input, both sampled on the same clock edge. On every rising edge of a lane's pulse, the block checks that the framing byte it expects is in the position the pulse marks. When the check fails, it raises a one-cycle event and a sticky flag for that lane. Software or neighbouring logic clears the flag with a per-lane clear input. A held-high pulse is evaluated only once, on its rising edge.

Two bus widths are supported. In byte-pair mode the whole 16-bit word is used, and the marked byte is the upper one (bits 15..8). In nibble mode only bits 3..0 carry data: the pulse marks the most significant nibble, and the following cycle brings the low nibble. The expected position is normally the first A1 byte (0xF6). A second anchor setting instead expects the first byte after the last Z0 fill byte. When the lanes are bonded into one STS-192 stream, the block also checks that the pulses of all lanes rise in the same cycle, and it flags any skew between lanes.

Top module: `frame_pulse_align_chk`

## Requirements
- R1: In byte-pair mode (`bus_mode_i`=0) with the A1 anchor (`anchor_z0_i`=0), a pulse rise is aligned when the upper byte (bits 15..8) of that word is 0xF6 and the lower byte (bits 7..0) of the previous word is not 0xF6. The result appears on `misalign_evt_o` for one cycle, on the clock edge after the edge that sampled the rise.
- R2: In byte-pair mode, a pulse rise whose upper byte is not 0xF6 raises the misalignment event, including the case where 0xF6 sits only on the lower byte.
- R3: A pulse that rises on a later A1 byte (the byte just before the marked one is also 0xF6) counts as misaligned.
- R4: In nibble mode (`bus_mode_i`=1), only bits 3..0 of each lane are used. The nibble sampled with the rise is the high half of the marked byte, and the next cycle's nibble is the low half. The byte before it is made of the two nibbles that precede the rise. The R1/R3 rules apply to these bytes, and the event appears two edges after the rise was sampled.
- R5: With `anchor_z0_i`=1, a rise is aligned when the marked byte differs from the Z0 fill value (parameter, default 0xCC) and the byte just before it equals the fill value. Any other combination is misaligned.
- R6: A pulse held high for several cycles is evaluated only on its rising edge. An event never occurs without the pulse having been high one or two cycles earlier.
- R7: `misalign_flag_o[i]` is set by an event on lane i and stays set until `misalign_clr_i[i]` is sampled high. If an event and a clear occur in the same cycle, the flag stays set.
- R8: With `combined_i`=1, a cycle in which some lanes but not all see a pulse rise raises `skew_evt_o` on the next edge and sets the sticky `skew_flag_o`, which `skew_clr_i` clears. A rise on all lanes together raises nothing.
- R9: With `combined_i`=0, no skew is reported, whatever the pulse pattern.
- R10: After reset, all events and flags are low.
- R11: Lanes are checked independently: a misaligned pulse on one lane sets only that lane's event and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lane clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_mode_i | input | 1 | 0 = 16-bit byte-pair, 1 = 4-bit nibble |
| anchor_z0_i | input | 1 | 0 = expect first A1, 1 = expect first byte after last Z0 |
| combined_i | input | 1 | 1 = lanes bonded into one stream, check skew |
| lane_data_i | input | NUM_LANES*LANE_W | Lane data, lane i at bits [i*LANE_W +: LANE_W] |
| lane_fp_i | input | NUM_LANES | Frame pulse per lane |
| misalign_clr_i | input | NUM_LANES | Write-one-to-clear for the misalignment flags |
| skew_clr_i | input | 1 | Write-one-to-clear for the skew flag |
| misalign_evt_o | output | NUM_LANES | One-cycle misalignment event per lane |
| misalign_flag_o | output | NUM_LANES | Sticky misalignment flag per lane |
| skew_evt_o | output | 1 | One-cycle lane skew event |
| skew_flag_o | output | 1 | Sticky lane skew flag |

## Verification
A stale pulse-history register would fire an event on the second cycle of a held pulse, one edge later than a correct rise. A wrong previous-byte register would accept a late A1 or reject a correct Z0 anchor, and this shows on the event output on the very next edge. In nibble mode, a pending-check register that is lost or never cleared shows up two edges after the rise, as a missing or repeated event. Skew logic that mixes up level and edge would report skew on a held lane while a lagging lane rises, in the same cycle that the bench expects the lagging event.

// File: rtl/fpac_pkg.sv
package fpac_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam logic [7:0]  A1_BYTE = 8'hF6;

    typedef enum logic {
        BUS_BYTE_PAIR = 1'b0,
        BUS_NIBBLE    = 1'b1
    } bus_mode_e;

    typedef enum logic {
        ANCHOR_A1       = 1'b0,
        ANCHOR_AFTER_Z0 = 1'b1
    } anchor_e;

    // True when the marked byte and its predecessor satisfy the selected anchor
    function automatic logic anchor_ok(anchor_e a, logic [7:0] cur, logic [7:0] prv,
                                       logic [7:0] z0);
        if (a == ANCHOR_A1) return (cur == A1_BYTE) && (prv != A1_BYTE);
        return (cur != z0) && (prv == z0);
    endfunction

endpackage

// File: rtl/fpac_lane.sv
module fpac_lane
    import fpac_pkg::*;
#(
    parameter int unsigned LANE_W  = 16,
    parameter int unsigned NIB_W   = 4,
    parameter logic [7:0]  Z0_BYTE = 8'hCC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         bus_mode,
    input  anchor_e           anchor,
    input  logic [LANE_W-1:0] data_i,
    input  logic              fp_i,
    input  logic              clr_i,
    output logic              rise_o,
    output logic              evt_o,
    output logic              flag_o
);
    localparam int unsigned HIST_KEEP = BYTE_W - NIB_W;

    typedef struct packed {
        logic              fp;
        logic [BYTE_W-1:0] prev_lo;
        logic [BYTE_W-1:0] nib_hist;
        logic              pend;
        logic [NIB_W-1:0]  pend_hi;
        logic [BYTE_W-1:0] pend_prev;
        logic              evt;
        logic              flag;
    } lane_st_t;

    lane_st_t st_q, st_d;
    logic rise, chk_wide, bad_wide, bad_narrow;

    always_comb begin
        st_d = st_q;
        rise = fp_i & ~st_q.fp;

        st_d.fp       = fp_i;
        st_d.prev_lo  = data_i[BYTE_W-1:0];
        st_d.nib_hist = {st_q.nib_hist[HIST_KEEP-1:0], data_i[NIB_W-1:0]};

        chk_wide   = rise && (bus_mode == BUS_BYTE_PAIR);
        bad_wide   = !anchor_ok(anchor, data_i[LANE_W-1 -: BYTE_W], st_q.prev_lo, Z0_BYTE);
        bad_narrow = !anchor_ok(anchor, {st_q.pend_hi, data_i[NIB_W-1:0]},
                                st_q.pend_prev, Z0_BYTE);

        st_d.pend = rise && (bus_mode == BUS_NIBBLE);
        if (st_d.pend) begin
            st_d.pend_hi   = data_i[NIB_W-1:0];
            st_d.pend_prev = st_q.nib_hist;
        end

        st_d.evt  = (chk_wide & bad_wide) | (st_q.pend & bad_narrow);
        st_d.flag = (st_q.flag & ~clr_i) | st_d.evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = rise;
    assign evt_o  = st_q.evt;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/fpac_skew.sv
module fpac_skew #(
    parameter int unsigned NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 combined_i,
    input  logic [NUM_LANES-1:0] rise_i,
    input  logic                 clr_i,
    output logic                 evt_o,
    output logic                 flag_o
);
    typedef struct packed {
        logic evt;
        logic flag;
    } skew_st_t;

    skew_st_t st_q, st_d;
    logic partial;

    always_comb begin
        st_d    = st_q;
        partial = combined_i && (|rise_i) && !(&rise_i);
        st_d.evt  = partial;
        st_d.flag = (st_q.flag & ~clr_i) | partial;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o  = st_q.evt;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/frame_pulse_align_chk.sv
module frame_pulse_align_chk
    import fpac_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned LANE_W    = 16,
    parameter int unsigned NIB_W     = 4,
    parameter logic [7:0]  Z0_BYTE   = 8'hCC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_mode_i,
    input  logic                        anchor_z0_i,
    input  logic                        combined_i,
    input  logic [NUM_LANES*LANE_W-1:0] lane_data_i,
    input  logic [NUM_LANES-1:0]        lane_fp_i,
    input  logic [NUM_LANES-1:0]        misalign_clr_i,
    input  logic                        skew_clr_i,
    output logic [NUM_LANES-1:0]        misalign_evt_o,
    output logic [NUM_LANES-1:0]        misalign_flag_o,
    output logic                        skew_evt_o,
    output logic                        skew_flag_o
);
    bus_mode_e            bus_mode;
    anchor_e              anchor;
    logic [NUM_LANES-1:0] lane_rise;

    assign bus_mode = bus_mode_e'(bus_mode_i);
    assign anchor   = anchor_e'(anchor_z0_i);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        fpac_lane #(
            .LANE_W (LANE_W),
            .NIB_W  (NIB_W),
            .Z0_BYTE(Z0_BYTE)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .bus_mode(bus_mode),
            .anchor  (anchor),
            .data_i  (lane_data_i[i*LANE_W +: LANE_W]),
            .fp_i    (lane_fp_i[i]),
            .clr_i   (misalign_clr_i[i]),
            .rise_o  (lane_rise[i]),
            .evt_o   (misalign_evt_o[i]),
            .flag_o  (misalign_flag_o[i])
        );
    end

    fpac_skew #(
        .NUM_LANES(NUM_LANES)
    ) u_skew (
        .clk       (clk),
        .rst_n     (rst_n),
        .combined_i(combined_i),
        .rise_i    (lane_rise),
        .clr_i     (skew_clr_i),
        .evt_o     (skew_evt_o),
        .flag_o    (skew_flag_o)
    );

endmodule

// File: rtl/frame_pulse_align_chk_sva.sv
module frame_pulse_align_chk_sva #(
    parameter int unsigned NUM_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 combined_i,
    input logic [NUM_LANES-1:0] lane_fp_i,
    input logic [NUM_LANES-1:0] misalign_clr_i,
    input logic                 skew_clr_i,
    input logic [NUM_LANES-1:0] misalign_evt_o,
    input logic [NUM_LANES-1:0] misalign_flag_o,
    input logic                 skew_evt_o,
    input logic                 skew_flag_o
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            misalign_evt_o[i] |-> misalign_flag_o[i]); // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(misalign_flag_o[i]) && !$past(misalign_clr_i[i]) |-> misalign_flag_o[i]); // R7
        AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            $past(misalign_clr_i[i]) && !misalign_evt_o[i] |-> !misalign_flag_o[i]); // R7
        AST_EVT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            misalign_evt_o[i] |-> ($past(lane_fp_i[i]) || $past(lane_fp_i[i], 2))); // R6
    end

    AST_SKEW_ONLY_BONDED: assert property (@(posedge clk) disable iff (!rst_n)
        skew_evt_o |-> $past(combined_i)); // R9
    AST_SKEW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        skew_evt_o |-> skew_flag_o); // R8
    AST_SKEW_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        skew_evt_o |-> ($past(lane_fp_i) != '0)); // R8
    AST_SKEW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(skew_clr_i) && !skew_evt_o |-> !skew_flag_o); // R8

endmodule

bind frame_pulse_align_chk frame_pulse_align_chk_sva #(
    .NUM_LANES(NUM_LANES)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .combined_i     (combined_i),
    .lane_fp_i      (lane_fp_i),
    .misalign_clr_i (misalign_clr_i),
    .skew_clr_i     (skew_clr_i),
    .misalign_evt_o (misalign_evt_o),
    .misalign_flag_o(misalign_flag_o),
    .skew_evt_o     (skew_evt_o),
    .skew_flag_o    (skew_flag_o)
);

// File: tb/frame_pulse_align_chk_test.sv
module frame_pulse_align_chk_test;
    localparam int NL = 4;
    localparam int LW = 16;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_mode = 1'b0, anchor_z0 = 1'b0, combined = 1'b0;
    logic [DW-1:0] lane_data = '0;
    logic [NL-1:0] lane_fp = '0, mis_clr = '0;
    logic          skew_clr = 1'b0;
    logic [NL-1:0] mis_evt, mis_flag;
    logic          skew_evt, skew_flag;

    int cyc = 0, drv_cyc = 0, checks = 0, fails = 0;
    bit run = 0, done = 0;

    int         q_cyc[$];
    logic [3:0] q_evt[$];
    logic       q_skew[$];
    string      q_tag[$];

    frame_pulse_align_chk uut (
        .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .anchor_z0_i(anchor_z0),
        .combined_i(combined), .lane_data_i(lane_data), .lane_fp_i(lane_fp),
        .misalign_clr_i(mis_clr), .skew_clr_i(skew_clr), .misalign_evt_o(mis_evt),
        .misalign_flag_o(mis_flag), .skew_evt_o(skew_evt), .skew_flag_o(skew_flag)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] on_lane(int i, logic [LW-1:0] v);
        return DW'(v) << (LW * i);
    endfunction

    task automatic step(input logic [DW-1:0] d, input logic [NL-1:0] fp,
                        input logic [NL-1:0] clr = '0, input logic sclr = 1'b0);
        @(posedge clk); #1;
        lane_data = d; lane_fp = fp; mis_clr = clr; skew_clr = sclr;
        drv_cyc = cyc;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step('0, '0);
    endtask

    task automatic expect_at(int c, logic [3:0] e, logic s, string tag);
        q_cyc.push_back(c); q_evt.push_back(e); q_skew.push_back(s); q_tag.push_back(tag);
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        @(negedge clk);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected events and compares every cycle
    always @(negedge clk) begin
        if (rst_n && run) begin
            logic [3:0] ee;
            logic       es;
            string      tg;
            ee = '0; es = 1'b0; tg = "R6/R9 quiet cycle";
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                ee = q_evt.pop_front(); es = q_skew.pop_front(); tg = q_tag.pop_front();
                void'(q_cyc.pop_front());
            end
            checks++;
            if (mis_evt !== ee || skew_evt !== es) begin
                fails++;
                $display("FAIL %s at cycle %0d: actual evt=%b skew=%b expected evt=%b skew=%b",
                         tg, cyc, mis_evt, skew_evt, ee, es);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R10 reset flags", {mis_flag, mis_evt}, 8'h00);
        check("R10 reset skew", {6'b0, skew_flag, skew_evt}, 8'h00);
        run = 1;
        idle(2);

        // R1 aligned on every lane, then held high (R6)
        step({NL{16'hF6F6}}, 4'hF); expect_at(drv_cyc + 1, 4'h0, 0, "R1 aligned");
        step({NL{16'hF6F6}}, 4'hF); expect_at(drv_cyc + 1, 4'h0, 0, "R6 held pulse");
        step({NL{16'hF6F6}}, 4'hF); expect_at(drv_cyc + 1, 4'h0, 0, "R6 held pulse");
        idle(3);
        check("R1 flags clean", {4'h0, mis_flag}, 8'h00);

        // R2 A1 only on lower byte, lane 1 (R11 independence)
        step(on_lane(1, 16'h00F6), 4'b0010); expect_at(drv_cyc + 1, 4'b0010, 0, "R2 low byte");
        idle(3);
        check("R11 only lane 1 flagged", {4'h0, mis_flag}, 8'h02);

        // R3 pulse on second A1, lane 2
        step(on_lane(2, 16'hF6F6), 4'b0000);
        step(on_lane(2, 16'hF6F6), 4'b0100); expect_at(drv_cyc + 1, 4'b0100, 0, "R3 late A1");
        idle(3);
        check("R3 flags", {4'h0, mis_flag}, 8'h06);

        // R7 clear, then set wins over clear
        step('0, '0, 4'b0110);
        idle(2);
        check("R7 cleared", {4'h0, mis_flag}, 8'h00);
        step(on_lane(0, 16'h1111), 4'b0001, 4'b0001);
        expect_at(drv_cyc + 1, 4'b0001, 0, "R7 set vs clear");
        idle(3);
        check("R7 set wins", {4'h0, mis_flag}, 8'h01);
        step('0, '0, 4'b0001);
        idle(2);
        check("R7 cleared again", {4'h0, mis_flag}, 8'h00);

        // R4 nibble mode, lane 3, upper bits carry junk
        bus_mode = 1'b1;
        step(on_lane(3, 16'hAB0C), 4'b0000);
        step(on_lane(3, 16'hAB0C), 4'b0000);
        step(on_lane(3, 16'hAB0F), 4'b1000); expect_at(drv_cyc + 2, 4'h0, 0, "R4 aligned nibble");
        step(on_lane(3, 16'hAB06), 4'b1000);
        idle(3);
        step(on_lane(3, 16'h0002), 4'b1000); expect_at(drv_cyc + 2, 4'b1000, 0, "R4 wrong byte");
        step(on_lane(3, 16'h0008), 4'b0000);
        idle(2);
        step(on_lane(3, 16'h000F), 4'b0000);
        step(on_lane(3, 16'h0006), 4'b0000);
        step(on_lane(3, 16'h000F), 4'b1000); expect_at(drv_cyc + 2, 4'b1000, 0, "R4 late A1");
        step(on_lane(3, 16'h0006), 4'b0000);
        idle(3);
        check("R4 flag lane 3", {4'h0, mis_flag}, 8'h08);
        step('0, '0, 4'b1000);
        bus_mode = 1'b0;
        idle(2);

        // R5 anchor after Z0 fill (0xCC), lane 0
        anchor_z0 = 1'b1;
        step(on_lane(0, 16'hCCCC), 4'b0000);
        step(on_lane(0, 16'h0102), 4'b0001); expect_at(drv_cyc + 1, 4'h0, 0, "R5 aligned");
        idle(2);
        step(on_lane(0, 16'hCCCC), 4'b0000);
        step(on_lane(0, 16'hCC02), 4'b0001); expect_at(drv_cyc + 1, 4'b0001, 0, "R5 still Z0");
        idle(2);
        step(on_lane(0, 16'h1234), 4'b0000);
        step(on_lane(0, 16'hF6F6), 4'b0001); expect_at(drv_cyc + 1, 4'b0001, 0, "R5 no Z0 before");
        idle(2);
        check("R5 flag lane 0", {4'h0, mis_flag}, 8'h01);
        step('0, '0, 4'b0001);
        anchor_z0 = 1'b0;
        idle(2);

        // R8 bonded lanes
        combined = 1'b1;
        step({NL{16'hF6F6}}, 4'hF); expect_at(drv_cyc + 1, 4'h0, 0, "R8 all together");
        idle(3);
        step({NL{16'hF628}}, 4'b0111); expect_at(drv_cyc + 1, 4'h0, 1, "R8 partial rise");
        step({NL{16'hF628}}, 4'b1111); expect_at(drv_cyc + 1, 4'h0, 1, "R8 lagging lane");
        idle(3);
        check("R8 skew flag set", {7'b0, skew_flag}, 8'h01);
        step('0, '0, '0, 1'b1);
        idle(2);
        check("R8 skew flag cleared", {7'b0, skew_flag}, 8'h00);

        // R9 unbonded partial rise
        combined = 1'b0;
        step(on_lane(0, 16'hF628), 4'b0001); expect_at(drv_cyc + 1, 4'h0, 0, "R9 unbonded");
        idle(3);
        check("R9 no skew flag", {4'h0, mis_flag, 3'b0, skew_flag}, 8'h00);

        checks++;
        if (q_cyc.size() != 0) begin
            fails++;
            $display("FAIL R1 scoreboard: actual %0d pending expected 0", q_cyc.size());
        end
        finish_run();
    end

endmodule